// File: doc/BRIEF.md
# Opcode Execute and Writeback Unit

This unit is the last stage of a small two-player core-battle machine. The operand stage has already resolved the current instruction. It delivers the opcode, both addressing modes, the two absolute pointers, the two terms and the two fetched instructions. From these the unit decides three things: what to write back into the circular core, where the current task goes next, and whether the task queue must drop the task or start a new one.

All address arithmetic wraps modulo the core size `CORE_SIZE`. A build parameter `MODE_1988` selects between two rule sets:

- The later rule set adds a skip-if-less opcode.
- Under the later rules, ADD and SUB with a non-immediate A-mode also combine the A-fields.
- The later rules change which pointer a fork uses as its target.

Every result is registered and appears one clock after `in_valid`.

Top module: `cx_exec_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `wr_en`, `task_kill`, `task_split` and `next_pc` are zero.
- R2: Each output is a registered result of the inputs sampled one clock earlier, and `out_valid` follows `in_valid` with one cycle of delay. A cycle without `in_valid` produces no write, no kill and no split.
- R3: MOVE (opcode 1) writes to `b_ptr`. When either mode is immediate (mode code 0), the write has `wr_kind` 0 (B-field only) and carries the A-term in the B-field. Otherwise the write has `wr_kind` 2 (whole instruction) and `wr_data` equals `a_instr`.
- R4: ADD (2) writes the B-term plus the A-term into the B-field at `b_ptr`. SUB (3) writes the B-term minus the A-term. Both results are reduced modulo `CORE_SIZE` and use `wr_kind` 0.
- R5: When `MODE_1988`=1 and the A-mode is not immediate, ADD and SUB use `wr_kind` 1 (A- and B-fields). The A-field carries the A-field of `b_instr` combined with the A-field of `a_instr` in the same way.
- R6: JUMP (4) sets `next_pc` to `a_ptr`. JZ (5) does so only when the B-term is zero, and JNZ (6) only when it is nonzero.
- R7: DECJ (7) writes the B-term minus one, modulo `CORE_SIZE`, into the B-field at `b_ptr`. It jumps to `a_ptr` when that decremented value is zero.
- R8: SKEQ (8) compares the two terms when either mode is immediate, and otherwise compares the whole instructions. On equality it sets `next_pc` to `cur_pc`+2 modulo `CORE_SIZE`.
- R9: Opcode 9 (SKLT) skips, giving `cur_pc`+2, when the A-term is less than the B-term and `MODE_1988`=1. When `MODE_1988`=0, opcode 9 kills the task.
- R10: FORK (10) raises `task_split` with `split_addr` equal to `b_ptr` when `MODE_1988`=0 and equal to `a_ptr` when `MODE_1988`=1.
- R11: HALT (0) and the unused opcodes 11 to 15 raise `task_kill`, with no write and no split.
- R12: Unless a rule above redirects it, `next_pc` is `cur_pc`+1 modulo `CORE_SIZE`, so it wraps from `CORE_SIZE`-1 to 0.

Instructions are packed, from MSB down, as {opcode[3:0], a_mode[1:0], a_field[AW-1:0], b_mode[1:0], b_field[AW-1:0]}, with AW = $clog2(`CORE_SIZE`). In a field write, the bits of `wr_data` that are not written are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands below are valid this cycle |
| opcode | input | 4 | Opcode of the current instruction |
| a_mode | input | 2 | A addressing mode (0 immediate) |
| b_mode | input | 2 | B addressing mode (0 immediate) |
| cur_pc | input | AW | Address of the current instruction |
| a_ptr | input | AW | Absolute A-pointer |
| b_ptr | input | AW | Absolute B-pointer |
| a_term | input | AW | Evaluated A-term |
| b_term | input | AW | Evaluated B-term |
| a_instr | input | IW | Instruction at the A-pointer |
| b_instr | input | IW | Instruction at the B-pointer |
| out_valid | output | 1 | Results below are valid |
| wr_en | output | 1 | Core write request |
| wr_kind | output | 2 | 0 B-field, 1 A- and B-fields, 2 whole instruction |
| wr_addr | output | AW | Core write address |
| wr_data | output | IW | Write data, in packed instruction layout |
| next_pc | output | AW | Next address for the current task |
| task_kill | output | 1 | Remove the current task |
| task_split | output | 1 | Insert a new task |
| split_addr | output | AW | Start address of the new task |

## Verification
The sweep targets the modulo edges:

- **Wrap of the next address.** A sum that reaches the core size must wrap to a small value, and the wrap of `cur_pc`+1 and `cur_pc`+2 at the top address must land near zero. A design that reduces these wrongly writes out-of-range fields or sends a task past the end of core.
- **Decrement-and-jump with a B-term of zero.** The decrement must give `CORE_SIZE`-1 and must not jump. A design that tests the term before decrementing jumps on the wrong value.
- **Mode-dependent forms.** Every mode pair is applied to MOVE and SKEQ, so taking the field form instead of the whole-instruction form, or the reverse, shows up as a wrong kind or a missed skip.
- **Rule-set differences and unused opcodes.** The later-rule A-field combine, the fork target and the opcode 9 case are each compared across both rule sets. A design that leaves unused opcodes undefined would let them write or fork instead of killing the task.

// File: rtl/cx_exec_pkg.sv
package cx_exec_pkg;

    typedef enum logic [3:0] {
        OP_HALT = 4'd0,
        OP_MOVE = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_JUMP = 4'd4,
        OP_JZ   = 4'd5,
        OP_JNZ  = 4'd6,
        OP_DECJ = 4'd7,
        OP_SKEQ = 4'd8,
        OP_SKLT = 4'd9,
        OP_FORK = 4'd10
    } cx_op_e;

    typedef enum logic [1:0] {
        MD_IMM = 2'd0,
        MD_DIR = 2'd1,
        MD_IND = 2'd2,
        MD_DEC = 2'd3
    } cx_mode_e;

    typedef enum logic [1:0] {
        WK_BFIELD = 2'd0,
        WK_ABFLD  = 2'd1,
        WK_FULL   = 2'd2
    } cx_wkind_e;

    typedef struct packed {
        logic kill;
        logic split;
        logic jump;
        logic skip;
    } cx_flow_s;

    // Map opcodes outside the active set onto HALT.
    function automatic logic [3:0] cx_legal_op(input logic [3:0] op, input logic late_rules);
        logic [3:0] r;
        r = op;
        if (op > 4'd10) r = 4'(OP_HALT);
        if (op == 4'(OP_SKLT) && !late_rules) r = 4'(OP_HALT);
        return r;
    endfunction

endpackage

// File: rtl/cx_mod_addsub.sv
module cx_mod_addsub #(
    parameter int AW      = 4,
    parameter int MODULUS = 10
) (
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    input  logic          do_sub,
    output logic [AW-1:0] r
);
    localparam logic [AW:0] MV = (AW+1)'(MODULUS);

    logic [AW:0] xe, ye, sum_raw, sum_red, dif;

    always_comb begin
        xe      = {1'b0, x};
        ye      = {1'b0, y};
        sum_raw = xe + ye;
        sum_red = (sum_raw >= MV) ? (sum_raw - MV) : sum_raw;
        dif     = (xe >= ye) ? (xe - ye) : (xe + MV - ye);
        r       = do_sub ? dif[AW-1:0] : sum_red[AW-1:0];
    end
endmodule

// File: rtl/cx_field_alu.sv
module cx_field_alu
    import cx_exec_pkg::*;
#(
    parameter int AW      = 4,
    parameter int MODULUS = 10
) (
    input  logic [3:0]    op,
    input  logic [AW-1:0] a_term,
    input  logic [AW-1:0] b_term,
    input  logic [AW-1:0] a_afield,
    input  logic [AW-1:0] b_afield,
    output logic [AW-1:0] b_res,
    output logic [AW-1:0] a_res,
    output logic          dec_zero
);
    logic          is_sub;
    logic [AW-1:0] bsum, bdec;

    assign is_sub = (op == 4'(OP_SUB));

    cx_mod_addsub #(.AW(AW), .MODULUS(MODULUS)) u_bfld (
        .x(b_term), .y(a_term), .do_sub(is_sub), .r(bsum));

    cx_mod_addsub #(.AW(AW), .MODULUS(MODULUS)) u_afld (
        .x(b_afield), .y(a_afield), .do_sub(is_sub), .r(a_res));

    cx_mod_addsub #(.AW(AW), .MODULUS(MODULUS)) u_dec (
        .x(b_term), .y(AW'(1)), .do_sub(1'b1), .r(bdec));

    assign b_res    = (op == 4'(OP_DECJ)) ? bdec : bsum;
    assign dec_zero = (bdec == '0);
endmodule

// File: rtl/cx_flow_ctl.sv
module cx_flow_ctl
    import cx_exec_pkg::*;
#(
    parameter int AW        = 4,
    parameter int IW        = 16,
    parameter int MODULUS   = 10,
    parameter bit LATE_RULE = 1'b0
) (
    input  logic [3:0]    op,
    input  logic [1:0]    a_mode,
    input  logic [1:0]    b_mode,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] a_ptr,
    input  logic [AW-1:0] b_ptr,
    input  logic [AW-1:0] a_term,
    input  logic [AW-1:0] b_term,
    input  logic [IW-1:0] a_instr,
    input  logic [IW-1:0] b_instr,
    input  logic          dec_zero,
    output cx_flow_s      flow,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] split_addr
);
    logic [AW-1:0] pc_inc, pc_skip;
    logic          any_imm, same;

    cx_mod_addsub #(.AW(AW), .MODULUS(MODULUS)) u_inc (
        .x(cur_pc), .y(AW'(1)), .do_sub(1'b0), .r(pc_inc));

    cx_mod_addsub #(.AW(AW), .MODULUS(MODULUS)) u_skip (
        .x(cur_pc), .y(AW'(2)), .do_sub(1'b0), .r(pc_skip));

    assign any_imm = (a_mode == 2'(MD_IMM)) || (b_mode == 2'(MD_IMM));
    assign same    = any_imm ? (a_term == b_term) : (a_instr == b_instr);

    always_comb begin
        flow = '0;
        case (op)
            4'(OP_HALT): flow.kill  = 1'b1;
            4'(OP_JUMP): flow.jump  = 1'b1;
            4'(OP_JZ):   flow.jump  = (b_term == '0);
            4'(OP_JNZ):  flow.jump  = (b_term != '0);
            4'(OP_DECJ): flow.jump  = dec_zero;
            4'(OP_SKEQ): flow.skip  = same;
            4'(OP_SKLT): flow.skip  = (a_term < b_term);
            4'(OP_FORK): flow.split = 1'b1;
            default: ;
        endcase
    end

    assign next_pc    = flow.jump ? a_ptr : (flow.skip ? pc_skip : pc_inc);
    assign split_addr = flow.split ? (LATE_RULE ? a_ptr : b_ptr) : '0;
endmodule

// File: rtl/cx_exec_unit.sv
module cx_exec_unit
    import cx_exec_pkg::*;
#(
    parameter int CORE_SIZE = 8000,
    parameter bit MODE_1988 = 1'b0,
    localparam int AW = $clog2(CORE_SIZE),
    localparam int IW = 8 + 2 * AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    opcode,
    input  logic [1:0]    a_mode,
    input  logic [1:0]    b_mode,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] a_ptr,
    input  logic [AW-1:0] b_ptr,
    input  logic [AW-1:0] a_term,
    input  logic [AW-1:0] b_term,
    input  logic [IW-1:0] a_instr,
    input  logic [IW-1:0] b_instr,
    output logic          out_valid,
    output logic          wr_en,
    output logic [1:0]    wr_kind,
    output logic [AW-1:0] wr_addr,
    output logic [IW-1:0] wr_data,
    output logic [AW-1:0] next_pc,
    output logic          task_kill,
    output logic          task_split,
    output logic [AW-1:0] split_addr
);
    localparam int          AFLD_LO = AW + 2;
    localparam logic [AW:0] MV      = (AW+1)'(CORE_SIZE);

    logic [3:0]    op;
    logic [AW-1:0] b_res, a_res, c_npc, c_split;
    logic          dec_zero, any_imm, c_wr;
    logic [1:0]    c_kind;
    logic [IW-1:0] c_data;
    cx_flow_s      flow;

    assign op      = cx_legal_op(opcode, MODE_1988);
    assign any_imm = (a_mode == 2'(MD_IMM)) || (b_mode == 2'(MD_IMM));

    cx_field_alu #(.AW(AW), .MODULUS(CORE_SIZE)) u_alu (
        .op(op), .a_term(a_term), .b_term(b_term),
        .a_afield(a_instr[AFLD_LO +: AW]), .b_afield(b_instr[AFLD_LO +: AW]),
        .b_res(b_res), .a_res(a_res), .dec_zero(dec_zero));

    cx_flow_ctl #(.AW(AW), .IW(IW), .MODULUS(CORE_SIZE), .LATE_RULE(MODE_1988)) u_flow (
        .op(op), .a_mode(a_mode), .b_mode(b_mode), .cur_pc(cur_pc),
        .a_ptr(a_ptr), .b_ptr(b_ptr), .a_term(a_term), .b_term(b_term),
        .a_instr(a_instr), .b_instr(b_instr), .dec_zero(dec_zero),
        .flow(flow), .next_pc(c_npc), .split_addr(c_split));

    always_comb begin
        c_wr   = 1'b0;
        c_kind = 2'(WK_BFIELD);
        c_data = '0;
        case (op)
            4'(OP_MOVE): begin
                c_wr = 1'b1;
                if (any_imm) begin
                    c_data[AW-1:0] = a_term;
                end else begin
                    c_kind = 2'(WK_FULL);
                    c_data = a_instr;
                end
            end
            4'(OP_ADD), 4'(OP_SUB): begin
                c_wr           = 1'b1;
                c_data[AW-1:0] = b_res;
                if (MODE_1988 && a_mode != 2'(MD_IMM)) begin
                    c_kind                 = 2'(WK_ABFLD);
                    c_data[AFLD_LO +: AW]  = a_res;
                end
            end
            4'(OP_DECJ): begin
                c_wr           = 1'b1;
                c_data[AW-1:0] = b_res;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            wr_en      <= 1'b0;
            wr_kind    <= '0;
            wr_addr    <= '0;
            wr_data    <= '0;
            next_pc    <= '0;
            task_kill  <= 1'b0;
            task_split <= 1'b0;
            split_addr <= '0;
        end else begin
            out_valid  <= in_valid;
            wr_en      <= in_valid && c_wr;
            wr_kind    <= c_kind;
            wr_addr    <= c_wr ? b_ptr : '0;
            wr_data    <= c_data;
            task_kill  <= in_valid && flow.kill;
            task_split <= in_valid && flow.split;
            split_addr <= c_split;
            if (in_valid) next_pc <= c_npc;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !task_kill && !task_split));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'(OP_JUMP)) |=> (next_pc == $past(a_ptr)));

    // R10
    fork_target_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'(OP_FORK)) |=>
            (task_split && split_addr == (MODE_1988 ? $past(a_ptr) : $past(b_ptr))));

    // R11
    kill_alone_chk: assert property (@(posedge clk) disable iff (rst)
        task_kill |-> (!wr_en && !task_split));

    // R12
    pc_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({1'b0, next_pc} < MV));

    // R4
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind != 2'(WK_FULL)) |-> ({1'b0, wr_data[AW-1:0]} < MV));
endmodule

// File: tb/tb_cx_exec_unit.sv
`timescale 1ns/1ps
module tb_cx_exec_unit;
    localparam int M  = 5;
    localparam int AW = $clog2(M);
    localparam int IW = 8 + 2 * AW;
    localparam int OW = 1 + 1 + 2 + AW + IW + AW + 1 + 1 + AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          in_valid;
    logic [3:0]    opcode;
    logic [1:0]    a_mode, b_mode;
    logic [AW-1:0] cur_pc, a_ptr, b_ptr, a_term, b_term;
    logic [IW-1:0] a_instr, b_instr;

    logic          v0, we0, k0, s0, v1, we1, k1, s1;
    logic [1:0]    wk0, wk1;
    logic [AW-1:0] wa0, np0, sa0, wa1, np1, sa1;
    logic [IW-1:0] wd0, wd1;

    cx_exec_unit #(.CORE_SIZE(M), .MODE_1988(1'b0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .a_mode(a_mode), .b_mode(b_mode), .cur_pc(cur_pc), .a_ptr(a_ptr),
        .b_ptr(b_ptr), .a_term(a_term), .b_term(b_term), .a_instr(a_instr),
        .b_instr(b_instr), .out_valid(v0), .wr_en(we0), .wr_kind(wk0),
        .wr_addr(wa0), .wr_data(wd0), .next_pc(np0), .task_kill(k0),
        .task_split(s0), .split_addr(sa0));

    cx_exec_unit #(.CORE_SIZE(M), .MODE_1988(1'b1)) dut88 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .a_mode(a_mode), .b_mode(b_mode), .cur_pc(cur_pc), .a_ptr(a_ptr),
        .b_ptr(b_ptr), .a_term(a_term), .b_term(b_term), .a_instr(a_instr),
        .b_instr(b_instr), .out_valid(v1), .wr_en(we1), .wr_kind(wk1),
        .wr_addr(wa1), .wr_data(wd1), .next_pc(np1), .task_kill(k1),
        .task_split(s1), .split_addr(sa1));

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    function automatic logic [OW-1:0] pack(input logic v, input logic we, input logic [1:0] wk,
                                           input logic [AW-1:0] wa, input logic [IW-1:0] wd,
                                           input logic [AW-1:0] np, input logic k, input logic s,
                                           input logic [AW-1:0] sa);
        if (!we) begin wk = '0; wa = '0; wd = '0; end
        if (!s) sa = '0;
        return {v, we, wk, wa, wd, np, k, s, sa};
    endfunction

    function automatic logic [IW-1:0] mk_instr(input int op, input int am, input int af,
                                               input int bm, input int bf);
        return {4'(op), 2'(am), AW'(af), 2'(bm), AW'(bf)};
    endfunction

    // Reference model written directly from the requirements.
    function automatic logic [OW-1:0] expect_out(input bit late, input int op, input int am,
            input int bm, input int pc, input int ap, input int bp, input int at, input int bt,
            input logic [IW-1:0] ai, input logic [IW-1:0] bi);
        logic we = 0, k = 0, s = 0;
        logic [1:0] wk = 0;
        logic [IW-1:0] wd = 0;
        int np = (pc + 1) % M;
        int sa = 0;
        int aaf = int'(ai[AW+2 +: AW]);
        int baf = int'(bi[AW+2 +: AW]);
        int eo = op;
        bit eq;
        if (op > 10 || (op == 9 && !late)) eo = 0;
        case (eo)
            0: k = 1;
            1: begin
                we = 1;
                if (am == 0 || bm == 0) wd = mk_instr(0, 0, 0, 0, at);
                else begin wk = 2; wd = ai; end
            end
            2, 3: begin
                int br, ar;
                we = 1;
                br = (eo == 2) ? (bt + at) % M : (bt - at + M) % M;
                ar = (eo == 2) ? (baf + aaf) % M : (baf - aaf + M) % M;
                if (late && am != 0) begin wk = 1; wd = mk_instr(0, 0, ar, 0, br); end
                else wd = mk_instr(0, 0, 0, 0, br);
            end
            4: np = ap;
            5: if (bt == 0) np = ap;
            6: if (bt != 0) np = ap;
            7: begin
                we = 1;
                wd = mk_instr(0, 0, 0, 0, (bt + M - 1) % M);
                if ((bt + M - 1) % M == 0) np = ap;
            end
            8: begin
                eq = (am == 0 || bm == 0) ? (at == bt) : (ai == bi);
                if (eq) np = (pc + 2) % M;
            end
            9: if (at < bt) np = (pc + 2) % M;
            default: begin s = 1; sa = late ? ap : bp; end
        endcase
        return pack(1'b1, we, wk, AW'(bp), wd, AW'(np), k, s, AW'(sa));
    endfunction

    function automatic string tag_of(input bit late, input int op, input int am);
        case (op)
            0: return "R11";
            1: return "R3/R12";
            2, 3: return (late && am != 0) ? "R5" : "R4/R12";
            4, 5, 6: return "R6/R12";
            7: return "R7";
            8: return "R8/R12";
            9: return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d am=%0d bm=%0d pc=%0d at=%0d bt=%0d act=%h exp=%h",
                     tag, opcode, a_mode, b_mode, cur_pc, a_term, b_term, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        in_valid = 0; opcode = 0; a_mode = 0; b_mode = 0; cur_pc = 0;
        a_ptr = 0; b_ptr = 0; a_term = 0; b_term = 0; a_instr = 0; b_instr = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cmp("R1", pack(v0, we0, wk0, wa0, wd0, np0, k0, s0, sa0), '0);
        cmp("R1", pack(v1, we1, wk1, wa1, wd1, np1, k1, s1, sa1), '0);
        rst = 1'b0;
        @(posedge clk); #1;
        cmp("R1", pack(v0, we0, wk0, wa0, wd0, np0, k0, s0, sa0), '0);

        for (int op = 0; op < 16; op++) begin
            for (int am = 0; am < 4; am++) begin
                for (int bm = 0; bm < 4; bm++) begin
                    for (int at = 0; at < M; at++) begin
                        for (int bt = 0; bt < M; bt++) begin
                            int pc = (at * 2 + bt + op + am) % M;
                            int ap = (pc + at + 2) % M;
                            int bp = (pc + bt + 3) % M;
                            logic [IW-1:0] ai, bi;
                            ai = mk_instr(at, bm, (at + 1) % M, am, at);
                            if (at == bt && (pc % 2) == 0) bi = ai;
                            else bi = mk_instr(bt, am, (bt + 2) % M, bm, bt);
                            in_valid = 1; opcode = 4'(op); a_mode = 2'(am); b_mode = 2'(bm);
                            cur_pc = AW'(pc); a_ptr = AW'(ap); b_ptr = AW'(bp);
                            a_term = AW'(at); b_term = AW'(bt); a_instr = ai; b_instr = bi;
                            @(posedge clk); #1;
                            cmp(tag_of(1'b0, op, am), pack(v0, we0, wk0, wa0, wd0, np0, k0, s0, sa0),
                                expect_out(1'b0, op, am, bm, pc, ap, bp, at, bt, ai, bi));
                            cmp(tag_of(1'b1, op, am), pack(v1, we1, wk1, wa1, wd1, np1, k1, s1, sa1),
                                expect_out(1'b1, op, am, bm, pc, ap, bp, at, bt, ai, bi));
                        end
                    end
                end
            end
            // R2: an idle cycle carrying a write opcode must do nothing
            in_valid = 0; opcode = 4'(OP_MOVE_VAL());
            @(posedge clk); #1;
            cmp("R2", {v0, we0, k0, s0}, '0);
            cmp("R2", {v1, we1, k1, s1}, '0);
        end
        finish_run();
    end

    function automatic int OP_MOVE_VAL();
        return 1;
    endfunction
endmodule